// File: doc/BRIEF.md
# Blocking-Pin Rotor Stepping Controller

This block keeps the stepping state for two independent groups of four rotors. One group turns clockwise and the other turns counter-clockwise. Every rotor owns a W-bit position counter (modulo N = 2^W) and an N-bit circular register of blocking pins. The pin registers are key material and are written serially, one bit per cycle. Each position counter can be written directly with its starting value.

On each symbol strobe, the first rotor of both groups always moves. Movement passes down each chain only as long as every earlier rotor shows a 1 at its pin tap, which is bit 0. A tap of 0 means a pin is present, and it stops every later rotor in that group. A moving rotor rotates its pin register one place and moves its counter one step in its group's direction.

All eight positions are presented as one flat vector for a substitution datapath. The number of rotors that moved in each group is registered with the step. The width W may be set to 4, 5 or 8 without touching the logic.

Top module: `rotor_step_ctrl`

## Requirements
- R1: After reset, all position counters, all pin registers and both step counts are 0.
- R2: While pin_we is high, the pin register selected by pin_sel takes one bit per cycle. The new bit enters at position N-1 and every other bit moves down one place, so after N writes the bit written k-th (counting from 0) sits at position k.
- R3: While off_we is high, the counter selected by off_sel takes the value off_val on that edge.
- R4: A step strobe in a cycle where pin_we or off_we is high is ignored: no rotor moves and both counts keep their value.
- R5: On an accepted step, rotor 0 of each group always moves.
- R6: Within a group, rotor k+1 moves only if rotor k moves and bit 0 of rotor k's pin register is 1. All taps are read from the values held before the edge.
- R7: A moving rotor rotates its pin register toward the high end: bit i goes to bit i+1, and bit N-1 goes to bit 0.
- R8: A moving clockwise rotor (indices 0 to 3) adds 1 to its counter modulo N. A moving counter-clockwise rotor (indices 4 to 7) subtracts 1 modulo N.
- R9: cnt_cw and cnt_ccw hold the number of rotors that moved in each group on the last accepted step, a value from 1 to 4. They keep that value until the next accepted step.
- R10: A rotor that does not move keeps its counter and its pin register, and with no step and no write nothing changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_we | input | 1 | Serial pin write strobe |
| pin_sel | input | 3 | Rotor whose pin register is written |
| pin_bit | input | 1 | Pin bit being written (1 = no pin) |
| off_we | input | 1 | Position counter write strobe |
| off_sel | input | 3 | Rotor whose counter is written |
| off_val | input | W | Counter value to write |
| step | input | 1 | Symbol strobe |
| offsets | output | 8*W | Rotor positions, rotor i at bits [i*W +: W] |
| cnt_cw | output | 3 | Rotors moved in the clockwise group |
| cnt_ccw | output | 3 | Rotors moved in the counter-clockwise group |

## Verification
The first key is all ones, so every tap passes and all four rotors move in both groups. The second key is all zeros, so only the first rotor moves. Together these two keys separate a broken chain from a chain that is stuck open.

A mixed key is then run for many symbols against an independent reference model. Because the taps change as the registers rotate, this checks the pin rotation direction and the before-the-edge tap sampling, and it exercises every count from 1 to 4.

Counters loaded at N-1 and 0 show wrap-around in each direction. A strobe issued during a counter write shows that the write wins and no rotor moves.

// File: rtl/rotor_step_ctrl.sv
module rotor_step_ctrl #(
  parameter int W      = 4,
  parameter int ROTORS = 4,
  localparam int N  = 1 << W,
  localparam int NR = 2 * ROTORS,
  localparam int SW = $clog2(NR),
  localparam int CW = $clog2(ROTORS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pin_we,
  input  logic [SW-1:0]  pin_sel,
  input  logic           pin_bit,
  input  logic           off_we,
  input  logic [SW-1:0]  off_sel,
  input  logic [W-1:0]   off_val,
  input  logic           step,
  output logic [NR*W-1:0] offsets,
  output logic [CW-1:0]  cnt_cw,
  output logic [CW-1:0]  cnt_ccw
);
  logic [NR-1:0] tap;
  logic [NR-1:0] mv;
  wire go = step & ~(pin_we | off_we);

  for (genvar s = 0; s < 2; s++) begin : g_set
    for (genvar k = 0; k < ROTORS; k++) begin : g_rot
      localparam int IDX = s * ROTORS + k;
      logic [N-1:0] pr;
      logic [W-1:0] po;

      if (k == 0) begin : g_head
        assign mv[IDX] = go;
      end else begin : g_link
        assign mv[IDX] = mv[IDX-1] & tap[IDX-1];
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pr <= '0;
          po <= '0;
        end else begin
          if (pin_we && pin_sel == SW'(IDX))
            pr <= {pin_bit, pr[N-1:1]};
          else if (mv[IDX])
            pr <= {pr[N-2:0], pr[N-1]};
          if (off_we && off_sel == SW'(IDX))
            po <= off_val;
          else if (mv[IDX])
            po <= (s == 0) ? po + W'(1) : po - W'(1);
        end
      end

      assign tap[IDX] = pr[0];
      assign offsets[IDX*W +: W] = po;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_cw  <= '0;
      cnt_ccw <= '0;
    end else if (go) begin
      cnt_cw  <= CW'($countones(mv[ROTORS-1:0]));
      cnt_ccw <= CW'($countones(mv[NR-1:ROTORS]));
    end
  end
endmodule

// File: rtl/rotor_step_chk.sv
module rotor_step_chk #(
  parameter int W      = 4,
  parameter int ROTORS = 4,
  localparam int NR = 2 * ROTORS,
  localparam int SW = $clog2(NR),
  localparam int CW = $clog2(ROTORS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pin_we,
  input logic [SW-1:0]   pin_sel,
  input logic            pin_bit,
  input logic            off_we,
  input logic [SW-1:0]   off_sel,
  input logic [W-1:0]    off_val,
  input logic            step,
  input logic [NR*W-1:0] offsets,
  input logic [CW-1:0]   cnt_cw,
  input logic [CW-1:0]   cnt_ccw
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;
  wire acc  = step & ~pin_we & ~off_we;
  wire quiet = ~step & ~pin_we & ~off_we;

  a_r5_cw_head_advances: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    acc |=> offsets[W-1:0] == $past(offsets[W-1:0]) + W'(1));

  a_r8_ccw_head_retreats: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    acc |=> offsets[ROTORS*W +: W] == $past(offsets[ROTORS*W +: W]) - W'(1));

  a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    acc |=> (cnt_cw >= CW'(1) && cnt_cw <= CW'(ROTORS) &&
             cnt_ccw >= CW'(1) && cnt_ccw <= CW'(ROTORS)));

  a_r4_write_blocks_step: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (step && (pin_we || off_we)) |=> ($stable(cnt_cw) && $stable(cnt_ccw)));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    quiet |=> ($stable(offsets) && $stable(cnt_cw) && $stable(cnt_ccw)));
endmodule

bind rotor_step_ctrl rotor_step_chk #(.W(W), .ROTORS(ROTORS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_we(pin_we), .pin_sel(pin_sel), .pin_bit(pin_bit),
  .off_we(off_we), .off_sel(off_sel), .off_val(off_val), .step(step),
  .offsets(offsets), .cnt_cw(cnt_cw), .cnt_ccw(cnt_ccw)
);

// File: tb/rotor_step_ctrl_tb.sv
`timescale 1ns/1ps
module rotor_step_ctrl_tb;
  localparam int W = 4;
  localparam int R = 4;
  localparam int N = 1 << W;
  localparam int NR = 2 * R;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_we = 1'b0, pin_bit = 1'b0, off_we = 1'b0, step = 1'b0;
  logic [2:0] pin_sel = '0, off_sel = '0;
  logic [W-1:0] off_val = '0;
  logic [NR*W-1:0] offsets;
  logic [2:0] cnt_cw, cnt_ccw;

  always #2 clk = ~clk;

  rotor_step_ctrl #(.W(W), .ROTORS(R)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_we(pin_we), .pin_sel(pin_sel), .pin_bit(pin_bit),
    .off_we(off_we), .off_sel(off_sel), .off_val(off_val), .step(step),
    .offsets(offsets), .cnt_cw(cnt_cw), .cnt_ccw(cnt_ccw));

  int tests = 0, fails = 0;
  logic [N-1:0] mp [NR];
  logic [W-1:0] mo [NR];
  int mc_cw = 0, mc_ccw = 0;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int i = 0; i < NR; i++) chk($sformatf("%s off%0d", tag, i), int'(offsets[i*W +: W]), int'(mo[i]));
    chk({tag, " cnt_cw"}, int'(cnt_cw), mc_cw);
    chk({tag, " cnt_ccw"}, int'(cnt_ccw), mc_ccw);
  endtask

  task automatic model_step();
    for (int s = 0; s < 2; s++) begin
      bit en = 1'b1;
      int c = 0;
      for (int k = 0; k < R; k++) begin
        int i = s * R + k;
        bit t = mp[i][0];
        if (en) begin
          mp[i] = {mp[i][N-2:0], mp[i][N-1]};
          mo[i] = (s == 0) ? mo[i] + W'(1) : mo[i] - W'(1);
          c++;
        end
        en = en & t;
      end
      if (s == 0) mc_cw = c; else mc_ccw = c;
    end
  endtask

  task automatic load_rotor(input int r, input logic [N-1:0] p, input logic [W-1:0] o);
    pin_we = 1'b1; pin_sel = 3'(r);
    off_we = 1'b1; off_sel = 3'(r); off_val = o;
    for (int k = 0; k < N; k++) begin
      pin_bit = p[k];
      @(negedge clk);
      off_we = 1'b0;
    end
    pin_we = 1'b0;
    mp[r] = p; mo[r] = o;
  endtask

  task automatic do_step();
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    model_step();
  endtask

  task automatic t_reset();
    for (int i = 0; i < NR; i++) begin mp[i] = '0; mo[i] = '0; end
    mc_cw = 0; mc_ccw = 0;
    chk_all("R1 reset");
  endtask

  task automatic t_all_open();
    for (int i = 0; i < NR; i++) load_rotor(i, '1, W'(i));
    chk_all("R2 R3 after load");
    for (int j = 0; j < 3; j++) begin
      do_step();
      chk_all("R6 R8 all taps open");
      chk("R6 cw count four", int'(cnt_cw), 4);
    end
  endtask

  task automatic t_all_blocked();
    for (int i = 0; i < NR; i++) load_rotor(i, '0, W'(3));
    for (int j = 0; j < 3; j++) begin
      do_step();
      chk_all("R5 R10 all pins present");
      chk("R5 ccw count one", int'(cnt_ccw), 1);
    end
  endtask

  task automatic t_wrap();
    for (int i = 0; i < NR; i++) load_rotor(i, '1, (i < R) ? W'(N-1) : W'(0));
    do_step();
    chk_all("R8 wrap");
    chk("R8 cw wrap to zero", int'(offsets[W-1:0]), 0);
    chk("R8 ccw wrap to top", int'(offsets[R*W +: W]), N-1);
  endtask

  task automatic t_mixed();
    for (int i = 0; i < NR; i++) begin
      logic [N-1:0] p = N'(32'h9E37_79B9 >> (i * 3)) ^ N'(32'h0000_5A5A * (i + 1));
      load_rotor(i, p, W'(i * 5));
    end
    for (int j = 0; j < 40; j++) begin
      do_step();
      chk_all("R6 R7 R8 mixed key");
    end
  endtask

  task automatic t_hold();
    for (int j = 0; j < 4; j++) @(negedge clk);
    chk_all("R9 R10 idle hold");
  endtask

  task automatic t_step_during_write();
    off_we = 1'b1; off_sel = 3'd2; off_val = W'(9); step = 1'b1;
    @(negedge clk);
    off_we = 1'b0; step = 1'b0;
    mo[2] = W'(9);
    chk_all("R4 R3 step during write");
    do_step();
    chk_all("R4 step after write");
  endtask

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_open();
    t_all_blocked();
    t_wrap();
    t_mixed();
    t_hold();
    t_step_during_write();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule